// File: doc/BRIEF.md
# Bank-Limited DMA Address Generator

This block produces the address sequence for one DMA channel. Each address is an 8-bit bank number placed above a 16-bit offset. Software fills three configuration registers through a small write port: the bank, the starting offset and the transfer length. It then pulses `start`. While the channel is busy it raises `bus_req` and presents the current address. Each cycle in which `bus_gnt` is also high uses up one word. After that word the offset steps forward by one and the remaining count drops by one.

The bank number stays fixed for the whole of a transfer. The block never lets a transfer run past the end of its 64K bank. When a start is requested, the block checks the starting offset and length together. If the transfer would pass the end of the bank, the block refuses it and raises a boundary-error flag, and no bus cycle is made. A buffer that lies across a bank edge has to be split by software into two transfers, with the bank register rewritten between them. The configuration registers are locked while a transfer runs.

Top module: `dma_bank_addr_gen`

## Requirements
- R1: `bus_addr` carries the bank register in bits 23:16 and the live offset in bits 15:0. Configuration selector codes are 0 for bank (`cfg_wdata[7:0]`), 1 for offset (`cfg_wdata[15:0]`) and 2 for length (`cfg_wdata[16:0]`). Code 3 writes nothing.
- R2: The bank bits of `bus_addr` do not change between the first and last requested cycle of a transfer.
- R3: On each clock edge where `bus_req` and `bus_gnt` are both high, the offset increases by one. On an edge with `bus_req` high and `bus_gnt` low, the address holds and no word is used.
- R4: A transfer of length N takes exactly N granted cycles. In the cycle after the edge of the last grant, `done` is high for exactly one cycle and `busy` and `bus_req` are low.
- R5: A start with length 0 raises `done` for one cycle, in the cycle after the start edge, and never raises `bus_req`.
- R6: If offset plus length is greater than 65536, a start raises `bound_err` in the next cycle and makes no bus request and no `done`. A sum of exactly 65536 is accepted.
- R7: `bound_err` stays high until the next accepted start. That start clears it.
- R8: Configuration writes made while `busy` is high are ignored. The current transfer is unaffected, and the register values from before the transfer are still there afterwards.
- R9: A `start` pulse while `busy` is high is ignored. The running transfer keeps its remaining count.
- R10: After reset the channel is idle, with `busy`, `bus_req`, `done` and `bound_err` low and all configuration registers zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select: 0 bank, 1 offset, 2 length |
| cfg_wdata | input | 17 | Configuration write data |
| start | input | 1 | Start pulse, taken only when idle |
| bus_gnt | input | 1 | Grant for the current requested cycle |
| bus_req | output | 1 | Request for a bus cycle at `bus_addr` |
| bus_addr | output | 24 | Bank and offset of the current word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| bound_err | output | 1 | Last start was refused for crossing a bank edge |

## Verification
The bench aims at the edge of the bank. One transfer ends exactly on the last offset, which must be accepted; a design that checks with greater-or-equal would refuse it. Another is one word longer, which must be refused; a design that carries into the next bank would instead emit an address in bank+1. It also runs a zero-length start. A design with a plain down-counter would wrap that into a 128K-word transfer instead of pulsing `done`. Finally it writes to the registers and pulses `start` in the middle of a transfer. A design missing the lock would shift the live address or restart the count, and a later restart would then pick up the wrong values.

// File: rtl/dmac_pkg.sv
// Shared types for the bank-limited DMA address generator.
// Assumes a two-bit configuration selector and a two-state channel.
package dmac_pkg;

    typedef enum logic [1:0] {
        SEL_BANK   = 2'd0,
        SEL_OFFSET = 2'd1,
        SEL_LENGTH = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/dmac_cfg_regs.sv
// Configuration registers: bank, start offset and length.
// Writes land on the clock edge and are dropped while 'lock' is high.
// Assumes BANK_W and OFS_W are no wider than the write data (LEN_W).
module dmac_cfg_regs #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    parameter int LEN_W  = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [LEN_W-1:0]  wdata,
    input  logic              lock,
    output logic [BANK_W-1:0] bank,
    output logic [OFS_W-1:0]  ofs,
    output logic [LEN_W-1:0]  len
);
    import dmac_pkg::*;

    logic wr_ok;

    // Write qualifier: a write counts only while the channel is idle.
    always_comb begin
        wr_ok = we && !lock;
    end

    // Register update: the selector picks the target register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= '0;
            ofs  <= '0;
            len  <= '0;
        end else if (wr_ok) begin
            case (cfg_sel_e'(sel))
                SEL_BANK:   bank <= wdata[BANK_W-1:0];
                SEL_OFFSET: ofs  <= wdata[OFS_W-1:0];
                SEL_LENGTH: len  <= wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/dmac_span_check.sv
// Combinational check of a requested span against the bank size.
// Flags a zero length and a span whose end passes 2**OFS_W.
// Assumes LEN_W is OFS_W+1, so a full bank length fits.
module dmac_span_check #(
    parameter int OFS_W = 16,
    parameter int LEN_W = OFS_W + 1
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] len,
    output logic             len_zero,
    output logic             overflow
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] BANK_SIZE = SUM_W'(1) << OFS_W;

    logic [SUM_W-1:0] span_end;

    // End of span: offset plus length, wide enough to never wrap.
    always_comb begin
        span_end = SUM_W'(ofs) + SUM_W'(len);
    end

    // Verdict: empty span, or span reaching past the bank edge.
    always_comb begin
        len_zero = (len == '0);
        overflow = (span_end > BANK_SIZE);
    end
endmodule

// File: rtl/dmac_sequencer.sv
// Channel control: takes a start while idle, steps the offset and
// count on each grant, and pulses done after the last word.
// Assumes the span checker outputs belong to the registered config.
module dmac_sequencer #(
    parameter int OFS_W = 16,
    parameter int LEN_W = OFS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFS_W-1:0] ofs,
    input  logic [LEN_W-1:0] len,
    input  logic             len_zero,
    input  logic             overflow,
    input  logic             gnt,
    output logic             req,
    output logic [OFS_W-1:0] cur_ofs,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import dmac_pkg::*;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    ch_state_e        state_q;
    logic [LEN_W-1:0] remain_q;
    logic             step;
    logic             last_word;

    // Step decode: a granted word, and whether it is the final one.
    always_comb begin
        step      = (state_q == CH_RUN) && gnt;
        last_word = step && (remain_q == ONE);
    end

    // Channel state, counters and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CH_IDLE;
            remain_q <= '0;
            cur_ofs  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                CH_IDLE: begin
                    if (start) begin
                        if (overflow) begin
                            err <= 1'b1;
                        end else begin
                            err <= 1'b0;
                            if (len_zero) begin
                                done <= 1'b1;
                            end else begin
                                state_q  <= CH_RUN;
                                cur_ofs  <= ofs;
                                remain_q <= len;
                            end
                        end
                    end
                end
                CH_RUN: begin
                    if (step) begin
                        cur_ofs  <= cur_ofs + 1'b1;
                        remain_q <= remain_q - ONE;
                    end
                    if (last_word) begin
                        state_q <= CH_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    // Outputs derived from state.
    always_comb begin
        busy = (state_q == CH_RUN);
        req  = busy;
    end
endmodule

// File: rtl/dma_bank_addr_gen.sv
// Top of the bank-limited DMA address generator.
// Joins the config registers, span check and sequencer; the address is
// the frozen bank over the live offset. Assumes one channel, no data path.
module dma_bank_addr_gen #(
    parameter int BANK_W = 8,
    parameter int OFS_W  = 16,
    parameter int LEN_W  = OFS_W + 1,
    parameter int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [LEN_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              busy,
    output logic              done,
    output logic              bound_err
);
    logic [BANK_W-1:0] bank_r;
    logic [OFS_W-1:0]  ofs_r;
    logic [LEN_W-1:0]  len_r;
    logic [OFS_W-1:0]  cur_ofs;
    logic              len_zero;
    logic              overflow;
    logic              busy_i;

    dmac_cfg_regs #(
        .BANK_W(BANK_W), .OFS_W(OFS_W), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .lock(busy_i),
        .bank(bank_r), .ofs(ofs_r), .len(len_r)
    );

    dmac_span_check #(
        .OFS_W(OFS_W), .LEN_W(LEN_W)
    ) u_span (
        .ofs(ofs_r), .len(len_r), .len_zero(len_zero), .overflow(overflow)
    );

    dmac_sequencer #(
        .OFS_W(OFS_W), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ofs(ofs_r), .len(len_r),
        .len_zero(len_zero), .overflow(overflow), .gnt(bus_gnt),
        .req(bus_req), .cur_ofs(cur_ofs), .busy(busy_i), .done(done),
        .err(bound_err)
    );

    // Address and busy outputs.
    always_comb begin
        bus_addr = {bank_r, cur_ofs};
        busy     = busy_i;
    end
endmodule

// File: rtl/dmac_checker.sv
// Port-level protocol checks for dma_bank_addr_gen, bound to every instance.
module dmac_checker #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              busy,
    input logic              done,
    input logic              bound_err
);
    assert_bank_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> (!bus_req || $stable(bus_addr[ADDR_W-1:OFS_W])));

    assert_step_on_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=>
        (!bus_req || bus_addr[OFS_W-1:0] == OFS_W'($past(bus_addr[OFS_W-1:0]) + 1'b1)));

    assert_hold_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !(bus_req && bus_addr[OFS_W-1:0] == '0));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !bus_req));

    assert_err_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bound_err |-> !bus_req);
endmodule

bind dma_bank_addr_gen dmac_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .busy(busy), .done(done), .bound_err(bound_err)
);

// File: tb/dma_bank_addr_gen_test.sv
module dma_bank_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd3;
    logic [16:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        bus_gnt = 1'b0;
    logic        bus_req;
    logic [23:0] bus_addr;
    logic        busy, done, bound_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_bank_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .bus_addr(bus_addr), .busy(busy), .done(done),
        .bound_err(bound_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [16:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic setup(input logic [7:0] b, input logic [15:0] o, input logic [16:0] l);
        wr(2'd0, {9'd0, b});   // R1 bank code 0
        wr(2'd1, {1'b0, o});   // R1 offset code 1
        wr(2'd2, l);           // R1 length code 2
    endtask

    // Pulse start; returns at the negedge after the start edge.
    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Runs a started transfer to its end, checking every address.
    task automatic drive(input logic [7:0] b, input logic [15:0] o, input int n,
                         input int pat, input string tag);
        int rem = n;
        logic [15:0] exp_o = o;
        int cyc = 0;
        while (rem > 0 && cyc < 4 * n + 8) begin
            bit g = (pat == 0) ? 1'b1 : ((cyc % pat) != 1);
            chk(bus_req === 1'b1 && busy === 1'b1, {tag, " R4 req"}, bus_req, 1);
            chk(bus_addr === {b, exp_o}, {tag, " R1 R2 R3 addr"}, bus_addr, {b, exp_o});
            chk(done === 1'b0, {tag, " R4 early done"}, done, 0);
            bus_gnt = g;
            @(negedge clk);
            if (g) begin exp_o = exp_o + 16'd1; rem--; end
            cyc++;
        end
        bus_gnt = 1'b0;
        chk(done === 1'b1 && busy === 1'b0 && bus_req === 1'b0, {tag, " R4 done"}, done, 1);
        @(negedge clk);
        chk(done === 1'b0, {tag, " R4 done width"}, done, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !bus_req && !done && !bound_err, "R10 flags", {busy, bus_req, done, bound_err}, 0);
        chk(bus_addr === 24'h0, "R10 regs", bus_addr, 0);
        kick();   // zero registers: length 0 -> done
        chk(done === 1'b1 && bus_req === 1'b0, "R10 R5 zero length after reset", done, 1);
        @(negedge clk);
    endtask

    task automatic t_basic();
        setup(8'h12, 16'h3400, 17'd5);
        kick();
        drive(8'h12, 16'h3400, 5, 0, "basic");
        setup(8'hA5, 16'h0100, 17'd7);
        kick();
        drive(8'hA5, 16'h0100, 7, 3, "gapped");
    endtask

    task automatic t_zero();
        setup(8'h01, 16'h2000, 17'd0);
        kick();
        chk(done === 1'b1 && bus_req === 1'b0 && busy === 1'b0, "R5 done", done, 1);
        @(negedge clk);
        chk(done === 1'b0 && bus_req === 1'b0, "R5 single", done, 0);
    endtask

    task automatic t_edge();
        setup(8'h07, 16'hFFF0, 17'd16);   // sum exactly 65536
        kick();
        chk(bound_err === 1'b0, "R6 exact fit accepted", bound_err, 0);
        drive(8'h07, 16'hFFF0, 16, 0, "R6 exact");
        setup(8'h07, 16'hFFF0, 17'd17);
        kick();
        chk(bound_err === 1'b1 && bus_req === 1'b0 && done === 1'b0, "R6 refuse", bound_err, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(bus_req === 1'b0 && done === 1'b0 && bound_err === 1'b1, "R6 R7 held", {bus_req, done, bound_err}, 1);
        end
        setup(8'h07, 16'hFFF0, 17'd2);
        chk(bound_err === 1'b1, "R7 not cleared by write", bound_err, 1);
        kick();
        chk(bound_err === 1'b0, "R7 cleared by start", bound_err, 0);
        drive(8'h07, 16'hFFF0, 2, 0, "R7 after");
    endtask

    task automatic t_split();
        setup(8'h03, 16'hFFFE, 17'd2);
        kick();
        drive(8'h03, 16'hFFFE, 2, 0, "R2 part1");
        setup(8'h04, 16'h0000, 17'd2);
        kick();
        drive(8'h04, 16'h0000, 2, 0, "R2 part2");
    endtask

    task automatic t_lock();
        setup(8'h55, 16'h1000, 17'd4);
        kick();
        wr(2'd0, 17'h000AA);
        wr(2'd1, 17'h02222);
        wr(2'd2, 17'd1);
        chk(bus_addr === 24'h551000, "R8 live address", bus_addr, 24'h551000);
        @(negedge clk);
        start = 1'b1;
        bus_gnt = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bus_gnt = 1'b0;
        chk(bus_addr === 24'h551001, "R9 start ignored", bus_addr, 24'h551001);
        drive(8'h55, 16'h1001, 3, 0, "R9 remain");
        kick();
        drive(8'h55, 16'h1000, 4, 0, "R8 regs kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_edge();
        t_split();
        t_lock();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule